// File: doc/BRIEF.md
# Buffered Serial Character Transmitter

This block turns host-written characters into asynchronous serial frames. A single holding register sits in front of a frame shifter: the host writes one character into the holding register whenever the ready flag is set, and as soon as transmission is enabled and the shifter is free, the character moves into the shifter. The holding register is then free again, so the host can queue the next character while the current one is still on the line.

A frame consists of a low start bit, then 7 or 8 data bits in LSB-first or MSB-first order, then an optional even or odd parity bit, then a high stop bit. Each bit lasts exactly one pulse of an externally generated baud tick. The shifter latches the character length, bit order and parity settings when it takes the character, so changing them later does not affect that frame. An interrupt line is high whenever the holding register is empty and the interrupt is enabled. Because the empty flag comes out of reset set, enabling the interrupt right after reset raises it at once. A busy output marks the span of the frame on the line.

Top module: `uart_txh_top`

## Requirements
- R1: After reset, `hold_empty` is 1, `txd` is 1 and `busy` is 0. Setting `irq_enable` to 1 then raises `tx_irq` without any write.
- R2: A write (`wr_en`=1) while `hold_empty`=1 stores `wr_data` and clears `hold_empty` on the next clock. A write while `hold_empty`=0 is ignored, and the stored character is kept.
- R3: A stored character moves to the shifter only while `tx_enable`=1 and the shifter holds no frame. `hold_empty` returns to 1 on the clock after the move. With `tx_enable`=0 the character stays pending and `txd` stays high.
- R4: `txd` idles high. The first `baud_tick` after a character is loaded drives the start bit, which is 0. After that, `txd` and `busy` change only on clocks where `baud_tick` is 1, so each bit lasts one tick.
- R5: The last frame bit is a stop bit of 1. `busy` rises with the start bit and falls on the tick that ends the stop bit.
- R6: When `msb_first`=0 the data bits go out starting with bit 0. When `msb_first`=1 they go out starting with the highest used bit.
- R7: When `len8`=1 the data bits are `wr_data[7:0]`. When `len8`=0 they are `wr_data[6:0]` and bit 7 is ignored in both bit orders. For MSB-first order, the first data bit is then bit 6.
- R8: When `par_en`=1, one parity bit follows the data bits, computed over the used data bits only. With `par_odd`=0 the parity bit makes the count of ones even; with `par_odd`=1 it makes the count odd. When `par_en`=0 the stop bit follows the data bits directly.
- R9: `tx_irq` is 1 exactly when `irq_enable`=1 and `hold_empty`=1.
- R10: Clearing `tx_enable` during a frame lets that frame finish unchanged. A character written afterwards is not loaded until `tx_enable` is set again.
- R11: The length, order and parity settings are latched when the character is loaded. Changes made after the load do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| tx_enable | input | 1 | Allows characters to move into the shifter |
| irq_enable | input | 1 | Enables the transmit interrupt |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| msb_first | input | 1 | 1: MSB-first, 0: LSB-first |
| par_en | input | 1 | Appends a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_irq | output | 1 | Transmit interrupt |
| busy | output | 1 | Frame on the line, from start bit through stop bit |

## Verification
The assertions check several rules on every cycle. They cover the flag handshake: a write into an empty register fills it, a full register stays full until a load, and a load empties it and happens only while enabled. They also cover line timing: the line is high when not busy, the start bit is low, the stop bit is high, `txd` and `busy` move only on ticks, and the interrupt is never high with the flag clear. Only the bench scenarios can show that the bit values on the line are right. That covers bit order for each length, the ignored bit 7, even and odd parity, a write dropped while full, a frame that finishes after the enable is cleared, and settings latched at load time.

// File: rtl/uart_txh_pkg.sv
package uart_txh_pkg;
  typedef enum logic [1:0] {
    TXS_IDLE  = 2'd0,
    TXS_ARMED = 2'd1,
    TXS_SHIFT = 2'd2
  } txs_e;
endpackage

// File: rtl/uart_txh_holdreg.sv
module uart_txh_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_ok,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty,
  output logic              write_acc,
  output logic              load_evt
);
  assign write_acc = wr_en & empty;
  assign load_evt  = ~empty & load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty     <= 1'b1;
      hold_data <= '0;
    end else if (write_acc) begin
      empty     <= 1'b0;
      hold_data <= wr_data;
    end else if (load_evt) begin
      empty <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_txh_shifter.sv
module uart_txh_shifter
  import uart_txh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [DATA_W-1:0] load_data,
  input  logic              len_full,
  input  logic              msb_first,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              baud_tick,
  output logic              txd,
  output logic              busy,
  output logic              idle
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int POS_W   = $clog2(FRAME_W);

  // Bits after the start bit, sent from bit 0 upward; unused positions are 1.
  function automatic logic [FRAME_W-1:0] build_frame(
      input logic [DATA_W-1:0] d, input logic full, input logic msb,
      input logic pe, input logic odd);
    logic [FRAME_W-1:0] f;
    logic [IDX_W-1:0]   src;
    logic               p;
    int                 nb;
    f  = '1;
    p  = odd;
    nb = full ? DATA_W : DATA_W - 1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) begin
        src  = msb ? IDX_W'(nb - 1 - i) : IDX_W'(i);
        f[i] = d[src];
        p    = p ^ d[i];
      end
    end
    if (pe) f[POS_W'(nb)] = p;
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic full, input logic pe);
    return CNT_W'(DATA_W - 1) + CNT_W'(full) + CNT_W'(pe) + CNT_W'(1);
  endfunction

  txs_e               state;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   remaining;
  logic               txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TXS_IDLE;
      sr        <= '1;
      remaining <= '0;
      txd_q     <= 1'b1;
    end else begin
      unique case (state)
        TXS_IDLE: if (load_evt) begin
          sr        <= build_frame(load_data, len_full, msb_first, par_en, par_odd);
          remaining <= frame_len(len_full, par_en);
          state     <= TXS_ARMED;
        end
        TXS_ARMED: if (baud_tick) begin
          txd_q <= 1'b0;
          state <= TXS_SHIFT;
        end
        TXS_SHIFT: if (baud_tick) begin
          if (remaining != '0) begin
            txd_q     <= sr[0];
            sr        <= {1'b1, sr[FRAME_W-1:1]};
            remaining <= remaining - CNT_W'(1);
          end else begin
            txd_q <= 1'b1;
            state <= TXS_IDLE;
          end
        end
        default: state <= TXS_IDLE;
      endcase
    end
  end

  assign txd  = txd_q;
  assign busy = (state == TXS_SHIFT);
  assign idle = (state == TXS_IDLE);
endmodule

// File: rtl/uart_txh_top.sv
module uart_txh_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_enable,
  input  logic              irq_enable,
  input  logic              len8,
  input  logic              msb_first,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              baud_tick,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_irq,
  output logic              busy
);
  logic [DATA_W-1:0] hold_data;
  logic              write_acc;
  logic              load_evt;
  logic              shifter_idle;

  uart_txh_holdreg #(.DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .load_ok   (tx_enable & shifter_idle),
    .hold_data (hold_data),
    .empty     (hold_empty),
    .write_acc (write_acc),
    .load_evt  (load_evt)
  );

  uart_txh_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .load_data (hold_data),
    .len_full  (len8),
    .msb_first (msb_first),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .baud_tick (baud_tick),
    .txd       (txd),
    .busy      (busy),
    .idle      (shifter_idle)
  );

  assign tx_irq = irq_enable & hold_empty;
endmodule

// File: rtl/uart_txh_chk.sv
module uart_txh_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tx_enable,
  input logic irq_enable,
  input logic baud_tick,
  input logic txd,
  input logic hold_empty,
  input logic tx_irq,
  input logic busy,
  input logic write_acc,
  input logic load_evt
);
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    write_acc |=> !hold_empty);
  p_full_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && !load_evt) |=> !hold_empty);
  p_load_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> hold_empty);
  p_load_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> tx_enable);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  p_tick_paced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> ($stable(txd) && $stable(busy)));
  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (txd && $past(txd)));
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (hold_empty && irq_enable));
endmodule

bind uart_txh_top uart_txh_chk i_chk (.*);

// File: tb/test_uart_txh_top.sv
`timescale 1ns/1ps
module test_uart_txh_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_enable = 1'b0;
  logic       irq_enable = 1'b0;
  logic       len8 = 1'b1;
  logic       msb_first = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       baud_tick = 1'b0;
  logic       txd, hold_empty, tx_irq, busy;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  uart_txh_top i_uart_txh_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .irq_enable(irq_enable), .len8(len8),
    .msb_first(msb_first), .par_en(par_en), .par_odd(par_odd),
    .baud_tick(baud_tick), .txd(txd), .hold_empty(hold_empty),
    .tx_irq(tx_irq), .busy(busy)
  );

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
    @(negedge clk);
  endtask

  // Expected bits after the start bit, from the requirement text.
  task automatic run_frame(input logic [7:0] d, input logic l8, input logic msb,
                           input logic pe, input logic odd, input string tag);
    logic exp_bits[$];
    int   nb = l8 ? 8 : 7;
    int   ones = 0;
    for (int k = 0; k < nb; k++) begin
      logic b = msb ? d[nb-1-k] : d[k];
      exp_bits.push_back(b);
      if (b) ones++;
    end
    if (pe) exp_bits.push_back(odd ? ((ones % 2) == 0) : ((ones % 2) == 1));
    exp_bits.push_back(1'b1);
    tick();
    chk(txd == 1'b0 && busy == 1'b1, {tag, " R4 start bit low, busy high"}, {busy, txd}, 2);
    foreach (exp_bits[k]) begin
      tick();
      chk(txd == exp_bits[k], $sformatf("%s R6 R7 R8 frame bit %0d", tag, k), txd, exp_bits[k]);
    end
    tick();
    chk(busy == 1'b0 && txd == 1'b1, {tag, " R5 busy falls after stop bit"}, {busy, txd}, 1);
  endtask

  task automatic t_reset();
    chk(hold_empty == 1'b1, "R1 empty after reset", hold_empty, 1);
    chk(txd == 1'b1 && busy == 1'b0, "R1 line idle after reset", {busy, txd}, 1);
    chk(tx_irq == 1'b0, "R9 irq low while disabled", tx_irq, 0);
    @(negedge clk); irq_enable = 1'b1;
    #1;
    chk(tx_irq == 1'b1, "R1 irq at once when enabled", tx_irq, 1);
  endtask

  task automatic t_disabled();
    do_write(8'h5A);
    chk(hold_empty == 1'b0, "R2 write clears empty", hold_empty, 0);
    chk(tx_irq == 1'b0, "R9 irq low while full", tx_irq, 0);
    tick(); tick();
    chk(hold_empty == 1'b0 && txd == 1'b1 && busy == 1'b0, "R3 no load while disabled",
        {hold_empty, busy, txd}, 1);
    @(negedge clk); tx_enable = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(hold_empty == 1'b1, "R3 load sets empty", hold_empty, 1);
    chk(tx_irq == 1'b1, "R9 irq back after load", tx_irq, 1);
    run_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, "disabled");
  endtask

  task automatic t_formats();
    len8 = 1; msb_first = 0; par_en = 0; par_odd = 0;
    do_write(8'hA5); run_frame(8'hA5, 1, 0, 0, 0, "8N lsb");
    len8 = 1; msb_first = 1; par_en = 1; par_odd = 0;
    do_write(8'h3D); run_frame(8'h3D, 1, 1, 1, 0, "8E msb");
    len8 = 0; msb_first = 0; par_en = 1; par_odd = 1;
    do_write(8'hD3); run_frame(8'hD3, 0, 0, 1, 1, "7O lsb bit7 set");
    len8 = 0; msb_first = 1; par_en = 1; par_odd = 0;
    do_write(8'hC1); run_frame(8'hC1, 0, 1, 1, 0, "7E msb bit7 set");
    // R11: settings changed after load do not affect the frame
    len8 = 1; msb_first = 0; par_en = 0; par_odd = 0;
    do_write(8'h96);
    msb_first = 1; par_en = 1; len8 = 0;
    run_frame(8'h96, 1, 0, 0, 0, "R11 latched format");
    len8 = 1; msb_first = 0; par_en = 0;
  endtask

  task automatic t_full_ignored();
    do_write(8'h11);
    do_write(8'h22);
    chk(hold_empty == 1'b0, "R2 full while shifter armed", hold_empty, 0);
    do_write(8'hEE);
    chk(hold_empty == 1'b0, "R2 still full after ignored write", hold_empty, 0);
    run_frame(8'h11, 1, 0, 0, 0, "first queued");
    chk(hold_empty == 1'b1, "R3 second char loaded after frame", hold_empty, 1);
    run_frame(8'h22, 1, 0, 0, 0, "R2 kept char not overwritten");
  endtask

  task automatic t_disable_midframe();
    do_write(8'h6B);
    tick(); tick(); tick();
    @(negedge clk); tx_enable = 1'b0;
    do_write(8'h44);
    for (int k = 2; k < 8; k++) begin
      tick();
      chk(txd == ((8'h6B >> k) & 1), "R10 frame continues after disable", txd, (8'h6B >> k) & 1);
    end
    tick();
    chk(txd == 1'b1 && busy == 1'b1, "R10 stop bit sent", {busy, txd}, 3);
    tick();
    chk(busy == 1'b0, "R10 frame ends", busy, 0);
    tick(); tick();
    chk(hold_empty == 1'b0 && busy == 1'b0 && txd == 1'b1, "R10 no load while disabled",
        {hold_empty, busy, txd}, 1);
    @(negedge clk); tx_enable = 1'b1;
    @(negedge clk); @(negedge clk);
    run_frame(8'h44, 1, 0, 0, 0, "R10 resumed");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_formats();
    t_full_ignored();
    t_disable_midframe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule